// File: doc/BRIEF.md
# Load Register Scoreboard

This block keeps one busy flag per architectural register so that instruction issue can run ahead of outstanding memory loads. When a load is admitted, the flag of its target register is raised. When the memory side writes the loaded value back, the flag drops. Every instruction presented for issue shows up to three register indices, two sources and a destination. The block raises `stall` only when one of the enabled indices still names a busy register, so instructions that do not depend on a pending load issue without delay.

The number of loads in flight is capped by the parameter `MAX_PEND`, which defaults to three. A small occupancy state machine tracks how many loads are pending. Its states are `OCC_EMPTY` (nothing pending), `OCC_PART` (some pending, room left) and `OCC_FULL` (limit reached). It moves from `OCC_EMPTY` to `OCC_PART` on an admitted load, or straight to `OCC_FULL` when the limit is one. It moves from `OCC_PART` to `OCC_FULL` when the pending count reaches the limit, and from `OCC_PART` back to `OCC_EMPTY` when the count returns to zero. It moves from `OCC_FULL` to `OCC_PART`, or to `OCC_EMPTY` when the limit is one, when a completion arrives with no new load. In every other case it stays where it is. While the block is full, a new load is refused unless a valid completion frees a slot in the same cycle. A completion that names a register with no pending load is reported on `wb_err` and changes nothing.

Top module: `pend_scoreboard`

## Requirements
- R1: After reset every busy flag is clear, the occupancy state is empty, `full` is 0, and no enabled check stalls.
- R2: A load with `ld_valid`=1 and `ld_accept`=1 marks register `ld_reg` busy from the next cycle on. A check naming that register then stalls.
- R3: A completion with `wb_valid`=1 that names a busy register clears that flag at the next clock edge. From the following cycle a check naming only that register no longer stalls.
- R4: `stall` is 1 exactly when at least one lane `l` has `chk_en[l]`=1 and the index in `chk_regs[5*l+4:5*l]` names a busy register. A disabled lane never stalls, whatever index it carries.
- R5: All three lanes are checked alike, including lane 2, which carries the destination. An instruction that writes a register with a pending load stalls.
- R6: At most three loads are pending. `full` is 1 exactly when three are pending. While `full` is 1 and no valid completion arrives, `ld_accept` is 0 and the load has no effect.
- R7: While `full` is 1, a load presented in the same cycle as a completion of a busy register is accepted. The count stays at three.
- R8: When a completion and an accepted load name the same register in the same cycle, the flag of that register is set afterwards.
- R9: A load whose target is already busy is refused (`ld_accept`=0) unless a completion of that register arrives in the same cycle. A refused load leaves the flags unchanged.
- R10: `wb_err` is 1 in the cycle a completion names a register that is not busy. Such a completion changes no flag and no count.
- R11: `stall` reflects the flags held at the start of the cycle. A completion does not drop the stall in its own cycle, and a load admitted in a cycle does not raise the stall in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load requests admission this cycle |
| ld_reg | input | 5 | Target register of the load |
| ld_accept | output | 1 | The load is admitted this cycle |
| wb_valid | input | 1 | Load data is written back this cycle |
| wb_reg | input | 5 | Register receiving the written-back data |
| wb_err | output | 1 | The write-back names a register with no pending load |
| chk_en | input | 3 | Per-lane enable of the issue check (lanes 0, 1 = sources, lane 2 = destination) |
| chk_regs | input | 15 | Lane indices, lane l in bits 5*l+4 down to 5*l |
| stall | output | 1 | Issue must wait: an enabled lane names a busy register |
| full | output | 1 | The pending-load limit is reached |

## Verification
Admission of a new load and retirement of a pending one can fall in the same cycle, and the hard cases are where they meet. One case is a completion arriving while the block is full. The other is a completion and a new load naming the same register. Directed sequences fill the block to three pending loads and then present a load together with a completion, once to a different register and once to the same register. The random phase confines indices to eight registers so that such meetings recur often. Each cycle, the bench predicts `ld_accept`, `stall`, `wb_err` and `full` from its own flag model and compares all four, so a wrong priority between set and clear surfaces as a stall or acceptance mismatch in the following cycles.

// File: rtl/pend_sb_pkg.sv
package pend_sb_pkg;

    // Occupancy of the pending-load tracker
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_t;

endpackage

// File: rtl/pend_sb_busyvec.sv
module pend_sb_busyvec #(
    parameter int NREG = 32,
    parameter int IW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [IW-1:0]   set_idx,
    input  logic            clr_en,
    input  logic [IW-1:0]   clr_idx,
    output logic [NREG-1:0] busy
);

    // One flag per register; a set in the same cycle as a clear wins
    for (genvar r = 0; r < NREG; r++) begin : g_flag
        logic hit_set;
        logic hit_clr;

        always_comb begin
            hit_set = set_en && (set_idx == IW'(r));
            hit_clr = clr_en && (clr_idx == IW'(r));
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[r] <= 1'b0;
            end else if (hit_set) begin
                busy[r] <= 1'b1;
            end else if (hit_clr) begin
                busy[r] <= 1'b0;
            end
        end
    end

    // R8: same-register clear and set leave the flag raised
    p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && clr_en && set_idx == clr_idx) |=> busy[$past(set_idx)]);

    // R3: a clear with no colliding set drops the flag
    p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !busy[$past(clr_idx)]);

endmodule

// File: rtl/pend_sb_occ.sv
module pend_sb_occ
    import pend_sb_pkg::*;
#(
    parameter int MAXP = 3,
    parameter int CW   = $clog2(MAXP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          full
);

    localparam logic [CW-1:0] MAXC = CW'(MAXP);

    occ_state_t    state_q;
    occ_state_t    state_d;
    logic [CW-1:0] cnt_d;

    always_comb begin
        cnt_d = count;
        if (inc && !dec) begin
            cnt_d = count + 1'b1;
        end else if (dec && !inc) begin
            cnt_d = count - 1'b1;
        end
    end

    // Transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (inc) begin
                    state_d = (MAXP == 1) ? OCC_FULL : OCC_PART;
                end
            end
            OCC_PART: begin
                if (cnt_d == MAXC) begin
                    state_d = OCC_FULL;
                end else if (cnt_d == '0) begin
                    state_d = OCC_EMPTY;
                end
            end
            OCC_FULL: begin
                if (dec && !inc) begin
                    state_d = (MAXP == 1) ? OCC_EMPTY : OCC_PART;
                end
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // State and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            count   <= '0;
        end else begin
            state_q <= state_d;
            count   <= cnt_d;
        end
    end

    // Output decode
    always_comb begin
        full = (state_q == OCC_FULL);
    end

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= MAXC);

    p_full_means_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (count == MAXC));

    p_empty_means_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_EMPTY) |-> (count == '0));

    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_EMPTY) |-> !dec);

endmodule

// File: rtl/pend_sb_hazard.sv
module pend_sb_hazard #(
    parameter int NREG  = 32,
    parameter int IW    = $clog2(NREG),
    parameter int LANES = 3
) (
    input  logic [NREG-1:0]     busy,
    input  logic [LANES-1:0]    lane_en,
    input  logic [LANES*IW-1:0] lane_idx,
    output logic                stall
);

    logic [LANES-1:0] lane_hit;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            lane_hit[l] = lane_en[l] && busy[lane_idx[l*IW +: IW]];
        end
    end

    always_comb begin
        stall = |lane_hit;
    end

    // R4: a stall always has an enabled lane behind it
    always_comb begin
        a_stall_needs_lane_r4: assert (!stall || (|lane_en));
    end

endmodule

// File: rtl/pend_scoreboard.sv
module pend_scoreboard #(
    parameter int NREG     = 32,
    parameter int MAX_PEND = 3,
    parameter int LANES    = 3,
    parameter int IW       = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_valid,
    input  logic [IW-1:0]       ld_reg,
    output logic                ld_accept,
    input  logic                wb_valid,
    input  logic [IW-1:0]       wb_reg,
    output logic                wb_err,
    input  logic [LANES-1:0]    chk_en,
    input  logic [LANES*IW-1:0] chk_regs,
    output logic                stall,
    output logic                full
);

    localparam int CW = $clog2(MAX_PEND + 1);

    logic [NREG-1:0] busy;
    logic [CW-1:0]   pend_cnt;
    logic            wb_good;
    logic            wb_same;
    logic            room;

    // Admission and retirement decisions
    always_comb begin
        wb_good   = wb_valid && busy[wb_reg];
        wb_err    = wb_valid && !busy[wb_reg];
        wb_same   = wb_good && (wb_reg == ld_reg);
        room      = !full || wb_good;
        ld_accept = ld_valid && room && (!busy[ld_reg] || wb_same);
    end

    pend_sb_busyvec #(
        .NREG (NREG),
        .IW   (IW)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (ld_accept),
        .set_idx (ld_reg),
        .clr_en  (wb_good),
        .clr_idx (wb_reg),
        .busy    (busy)
    );

    pend_sb_occ #(
        .MAXP (MAX_PEND),
        .CW   (CW)
    ) u_occ (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ld_accept),
        .dec   (wb_good),
        .count (pend_cnt),
        .full  (full)
    );

    pend_sb_hazard #(
        .NREG  (NREG),
        .IW    (IW),
        .LANES (LANES)
    ) u_hazard (
        .busy     (busy),
        .lane_en  (chk_en),
        .lane_idx (chk_regs),
        .stall    (stall)
    );

    // R6: flags and pending count agree
    p_flags_match_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(busy) == int'(pend_cnt));

    // R6: no admission when full and nothing retires
    p_no_admit_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !wb_valid) |-> !ld_accept);

    // R2: an admitted load shows up busy next cycle
    p_load_marks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_accept |=> busy[$past(ld_reg)]);

    // R10: an unmatched completion with no load leaves everything untouched
    p_err_is_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_err && !ld_accept) |=> $stable(busy));

    // R9: a refused load does not disturb a flag it names
    p_refused_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_accept && !wb_valid) |=> $stable(busy));

endmodule

// File: tb/pend_scoreboard_tb.sv
`timescale 1ns/1ps
module pend_scoreboard_tb;

    localparam int IW = 5;
    localparam int NR = 32;
    localparam int MP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [IW-1:0] ld_reg = '0;
    logic          ld_accept;
    logic          wb_valid = 1'b0;
    logic [IW-1:0] wb_reg = '0;
    logic          wb_err;
    logic [2:0]    chk_en = '0;
    logic [14:0]   chk_regs = '0;
    logic          stall;
    logic          full;

    int      n_run  = 0;
    int      n_fail = 0;
    bit      done   = 1'b0;
    bit      m_busy [NR];
    int      m_cnt  = 0;

    always #2.5 clk = ~clk;

    pend_scoreboard u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_reg    (ld_reg),
        .ld_accept (ld_accept),
        .wb_valid  (wb_valid),
        .wb_reg    (wb_reg),
        .wb_err    (wb_err),
        .chk_en    (chk_en),
        .chk_regs  (chk_regs),
        .stall     (stall),
        .full      (full)
    );

    function automatic bit f_good();
        return wb_valid && m_busy[wb_reg];
    endfunction

    function automatic bit f_accept();
        bit g = f_good();
        return ld_valid && (m_cnt < MP || g) && (!m_busy[ld_reg] || (g && wb_reg == ld_reg));
    endfunction

    function automatic bit f_stall();
        bit s = 1'b0;
        for (int l = 0; l < 3; l++) begin
            if (chk_en[l] && m_busy[chk_regs[l*IW +: IW]]) s = 1'b1;
        end
        return s;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive inputs, compare all outputs to the model, then clock once
    task automatic step(bit lv, int ld, bit wv, int wd, logic [2:0] en,
                        int a, int b, int c);
        bit acc;
        bit good;
        ld_valid = lv; ld_reg = IW'(ld);
        wb_valid = wv; wb_reg = IW'(wd);
        chk_en = en;
        chk_regs = {IW'(c), IW'(b), IW'(a)};
        #1;
        acc  = f_accept();
        good = f_good();
        check("R4 stall", int'(stall), int'(f_stall()));
        check("R6 ld_accept", int'(ld_accept), int'(acc));
        check("R10 wb_err", int'(wb_err), int'(wv && !m_busy[wb_reg]));
        check("R6 full", int'(full), int'(m_cnt == MP));
        @(posedge clk);
        if (good) m_busy[wd] = 1'b0;
        if (acc)  m_busy[ld] = 1'b1;
        m_cnt = m_cnt + int'(acc) - int'(good);
        @(negedge clk);
    endtask

    task automatic idle_check(int a, logic [2:0] en);
        step(0, 0, 0, 0, en, a, a, a);
    endtask

    initial begin
        void'($urandom(32'd7));
        for (int i = 0; i < NR; i++) m_busy[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk_en = 3'b111; chk_regs = '0;
        #1;
        check("R1 stall after reset", int'(stall), 0);
        check("R1 full after reset", int'(full), 0);
        @(negedge clk);

        // R2 and R11: admitted load does not stall in its own cycle, stalls after
        step(1, 4, 0, 0, 3'b001, 4, 0, 0);
        ld_valid = 0; chk_en = 3'b001; chk_regs = 15'd4; #1;
        check("R2 stall on busy source", int'(stall), 1);
        // R4: disabled lane naming the busy register
        chk_en = 3'b110; #1;
        check("R4 disabled lane no stall", int'(stall), 0);
        // R5: destination lane
        chk_en = 3'b100; chk_regs = {IW'(4), IW'(1), IW'(2)}; #1;
        check("R5 destination lane stall", int'(stall), 1);
        @(negedge clk);

        // R9: second load to register 4 refused
        step(1, 4, 0, 0, 3'b000, 0, 0, 0);
        check("R9 busy count unchanged", m_cnt, 1);

        // R11: completion does not release in its own cycle
        ld_valid = 0; wb_valid = 1; wb_reg = 5'd4;
        chk_en = 3'b001; chk_regs = 15'd4; #1;
        check("R11 stall held during completion", int'(stall), 1);
        @(posedge clk); m_busy[4] = 1'b0; m_cnt--; @(negedge clk);
        wb_valid = 0; #1;
        check("R3 stall released", int'(stall), 0);
        @(negedge clk);

        // R10: completion for idle register
        step(0, 0, 1, 9, 3'b000, 0, 0, 0);
        idle_check(9, 3'b001);

        // R6: fill to three, fourth refused
        step(1, 1, 0, 0, 3'b000, 0, 0, 0);
        step(1, 2, 0, 0, 3'b000, 0, 0, 0);
        step(1, 3, 0, 0, 3'b000, 0, 0, 0);
        ld_valid = 1; ld_reg = 5'd5; #1;
        check("R6 full at three", int'(full), 1);
        check("R6 fourth refused", int'(ld_accept), 0);
        @(negedge clk);
        idle_check(5, 3'b001);

        // R7: full plus completion admits the new load
        wb_valid = 1; wb_reg = 5'd1; ld_valid = 1; ld_reg = 5'd5; #1;
        check("R7 admitted while full", int'(ld_accept), 1);
        step(1, 5, 1, 1, 3'b000, 0, 0, 0);
        check("R7 count stays three", m_cnt, 3);

        // R8: completion and load on the same register
        wb_valid = 1; wb_reg = 5'd2; ld_valid = 1; ld_reg = 5'd2; #1;
        check("R8 same-register load accepted", int'(ld_accept), 1);
        step(1, 2, 1, 2, 3'b000, 0, 0, 0);
        chk_en = 3'b010; chk_regs = {IW'(0), IW'(2), IW'(0)}; #1;
        check("R8 flag remains set", int'(stall), 1);
        @(negedge clk);

        // Random phase over eight registers
        for (int k = 0; k < 3000; k++) begin
            bit lv = ($urandom % 2) == 1;
            int ld = $urandom % 8;
            bit wv = ($urandom % 3) != 0;
            int wd = $urandom % 8;
            if (wv && m_cnt > 0 && ($urandom % 4) != 0) begin
                int pick = $urandom % m_cnt;
                for (int r = 0; r < NR; r++) begin
                    if (m_busy[r]) begin
                        if (pick == 0) wd = r;
                        pick--;
                    end
                end
            end
            step(lv, ld, wv, wd, 3'($urandom), $urandom % 8, $urandom % 8, $urandom % 8);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule